// File: doc/BRIEF.md
# Bit-Level Pipelined Array Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. It is built as a grid of single-bit carry-save cells, and every cell output is registered. Operands move through the grid one row per clock as aligned wavefronts. A fresh operand pair may be offered on every clock. One complete product leaves the block on every clock once the pipeline has filled.

The front part has W rows of carry-save cells. Row r adds the partial product `in_x & {W{in_y[r]}}`, shifted left by r, into a running sum vector and a running carry vector. Each operand bit reaches its row on the right cycle through delay cells. The X word is passed down a chain of per-row registers. Each Y bit goes through a triangular skew of r registers.

The back part is a carry-propagate adder. It is pipelined in slices of SEG bits, and one register stage is used per slice. A valid flag travels beside the data through exactly the same number of stages. The total latency is W + 2W/SEG clocks.

Top module: `mul_wave_array`

## Requirements
- R1: While `rst_n` is low, and on the clock after any edge at which it was low, `out_valid` is 0.
- R2: For the default configuration (W=8, SEG=2), every result marked valid equals the unsigned product `in_x * in_y`, taken as 16 bits with no truncation.
- R3: An operand pair sampled with `in_valid`=1 at a rising edge appears on `out_prod` with `out_valid`=1 exactly L = W + 2W/SEG rising edges later. That is 16 for the default configuration and 12 for W=4, SEG=1.
- R4: A pair is accepted on every clock with no stall. Over a run, the number of clocks with `out_valid`=1 equals the number of pairs sampled with `in_valid`=1.
- R5: A clock sampled with `in_valid`=0 gives `out_valid`=0 exactly L edges later. The operands offered on that clock do not disturb the products of neighbouring valid pairs.
- R6: With W=4 and SEG=1, every valid result equals the unsigned 8-bit product of its operands.
- R7: Corner operands give exact results. A zero operand gives 0, and all-ones times all-ones gives 2^(2W) − 2^(W+1) + 1, which is 0xFE01 for W=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_x`/`in_y` as a pair to multiply this clock |
| in_x | input | W | Multiplicand, unsigned |
| in_y | input | W | Multiplier, unsigned; bit r is consumed by row r |
| out_valid | output | 1 | Marks `out_prod` as a finished product |
| out_prod | output | 2W | Unsigned product of the pair accepted L clocks earlier |

## Verification
The checker relies on two assumptions about the inputs. First, `in_valid` is a clean level that is sampled once per edge. Second, a pair is never withdrawn: a pair that has been sampled always produces one product. On that basis the checker counts pairs in flight and the idle run since the last accepted pair. The stimulus holds `in_valid`, `in_x` and `in_y` steady from one falling edge to the next. It sweeps every 8-bit × 8-bit pair, and the 4-bit instance is fed the low bits of the same sweep. A fixed pattern of bubble clocks is inserted so that idle cycles fall between back-to-back valid pairs.

// File: rtl/mul_wave_pkg.sv
package mul_wave_pkg;

   // carry of a single-bit full adder
   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   // clocks from operand sample to product for a given shape
   function automatic int unsigned pipe_latency(input int unsigned w, input int unsigned seg);
      return w + (2 * w) / seg;
   endfunction

endpackage

// File: rtl/mul_fa_cell.sv
module mul_fa_cell
   import mul_wave_pkg::*;
(
   input  logic clk,
   input  logic a,
   input  logic b,
   input  logic c,
   output logic s_q,
   output logic co_q
);

   always_ff @(posedge clk) begin
      s_q  <= a ^ b ^ c;
      co_q <= maj3(a, b, c);
   end

endmodule

// File: rtl/mul_csa_row.sv
module mul_csa_row #(
   parameter int unsigned W   = 8,
   parameter int unsigned ROW = 0
) (
   input  logic             clk,
   input  logic [W-1:0]     x_in,
   input  logic             y_bit,
   input  logic [2*W-1:0]   s_in,
   input  logic [2*W-1:0]   c_in,
   output logic [2*W-1:0]   s_q,
   output logic [2*W-1:0]   c_q
);

   localparam int unsigned P = 2 * W;

   logic [P-1:0] pp;
   logic [P-1:0] c_w;

   // partial product of this row, placed at weight 2^ROW
   assign pp  = {{W{1'b0}}, (x_in & {W{y_bit}})} << ROW;
   // carries of the previous row count one weight higher
   assign c_w = {c_in[P-2:0], 1'b0};

   for (genvar j = 0; j < P; j++) begin : g_col
      mul_fa_cell u_cell (
         .clk  (clk),
         .a    (s_in[j]),
         .b    (c_w[j]),
         .c    (pp[j]),
         .s_q  (s_q[j]),
         .co_q (c_q[j])
      );
   end

endmodule

// File: rtl/mul_ripple_stage.sv
module mul_ripple_stage #(
   parameter int unsigned P   = 16,
   parameter int unsigned SEG = 2,
   parameter int unsigned IDX = 0
) (
   input  logic          clk,
   input  logic [P-1:0]  a_in,
   input  logic [P-1:0]  b_in,
   input  logic [P-1:0]  sum_in,
   input  logic          c_in,
   output logic [P-1:0]  a_q,
   output logic [P-1:0]  b_q,
   output logic [P-1:0]  sum_q,
   output logic          c_q
);

   localparam int unsigned LO = IDX * SEG;

   logic [SEG:0]  slice;
   logic [P-1:0]  sum_nxt;

   always_comb begin
      slice   = {1'b0, a_in[LO +: SEG]} + {1'b0, b_in[LO +: SEG]} + {{SEG{1'b0}}, c_in};
      sum_nxt = sum_in;
      sum_nxt[LO +: SEG] = slice[SEG-1:0];
   end

   always_ff @(posedge clk) begin
      a_q   <= a_in;
      b_q   <= b_in;
      sum_q <= sum_nxt;
      c_q   <= slice[SEG];
   end

endmodule

// File: rtl/mul_wave_array.sv
module mul_wave_array
   import mul_wave_pkg::*;
#(
   parameter int unsigned W   = 8,
   parameter int unsigned SEG = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     in_x,
   input  logic [W-1:0]     in_y,
   output logic             out_valid,
   output logic [2*W-1:0]   out_prod
);

   localparam int unsigned P   = 2 * W;
   localparam int unsigned K   = P / SEG;
   localparam int unsigned LAT = pipe_latency(W, SEG);

   // elaboration-time shape checks
   if (W < 2) begin : g_bad_w
      $error("mul_wave_array: W must be at least 2");
   end
   if (SEG < 1 || (P % SEG) != 0 || K < 2) begin : g_bad_seg
      $error("mul_wave_array: SEG must divide 2*W into at least two slices");
   end

   // ---------------- operand skew ----------------
   logic [W-1:0] x_dly [W-1];
   logic [W-1:0] y_at;

   for (genvar r = 0; r < W - 1; r++) begin : g_xdly
      if (r == 0) begin : g_first
         always_ff @(posedge clk) x_dly[0] <= in_x;
      end else begin : g_next
         always_ff @(posedge clk) x_dly[r] <= x_dly[r-1];
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_yskew
      if (i == 0) begin : g_none
         assign y_at[0] = in_y[0];
      end else if (i == 1) begin : g_one
         logic sh;
         always_ff @(posedge clk) sh <= in_y[1];
         assign y_at[1] = sh;
      end else begin : g_many
         logic [i-1:0] sh;
         always_ff @(posedge clk) sh <= {sh[i-2:0], in_y[i]};
         assign y_at[i] = sh[i-1];
      end
   end

   // ---------------- carry-save rows ----------------
   logic [P-1:0] s_r [W];
   logic [P-1:0] c_r [W];

   for (genvar r = 0; r < W; r++) begin : g_row
      if (r == 0) begin : g_top
         mul_csa_row #(.W(W), .ROW(0)) u_row (
            .clk   (clk),
            .x_in  (in_x),
            .y_bit (y_at[0]),
            .s_in  ('0),
            .c_in  ('0),
            .s_q   (s_r[0]),
            .c_q   (c_r[0])
         );
      end else begin : g_body
         mul_csa_row #(.W(W), .ROW(r)) u_row (
            .clk   (clk),
            .x_in  (x_dly[r-1]),
            .y_bit (y_at[r]),
            .s_in  (s_r[r-1]),
            .c_in  (c_r[r-1]),
            .s_q   (s_r[r]),
            .c_q   (c_r[r])
         );
      end
   end

   // ---------------- sliced carry-propagate adder ----------------
   logic [P-1:0] ra [K];
   logic [P-1:0] rb [K];
   logic [P-1:0] rs [K];
   logic [K-1:0] rc;

   for (genvar k = 0; k < K; k++) begin : g_cpa
      if (k == 0) begin : g_lsb
         mul_ripple_stage #(.P(P), .SEG(SEG), .IDX(0)) u_stage (
            .clk    (clk),
            .a_in   (s_r[W-1]),
            .b_in   ({c_r[W-1][P-2:0], 1'b0}),
            .sum_in ('0),
            .c_in   (1'b0),
            .a_q    (ra[0]),
            .b_q    (rb[0]),
            .sum_q  (rs[0]),
            .c_q    (rc[0])
         );
      end else begin : g_up
         mul_ripple_stage #(.P(P), .SEG(SEG), .IDX(k)) u_stage (
            .clk    (clk),
            .a_in   (ra[k-1]),
            .b_in   (rb[k-1]),
            .sum_in (rs[k-1]),
            .c_in   (rc[k-1]),
            .a_q    (ra[k]),
            .b_q    (rb[k]),
            .sum_q  (rs[k]),
            .c_q    (rc[k])
         );
      end
   end

   assign out_prod = rs[K-1];

   // ---------------- valid pipeline ----------------
   logic [LAT-1:0] v_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) v_sr <= '0;
      else        v_sr <= {v_sr[LAT-2:0], in_valid};
   end

   assign out_valid = v_sr[LAT-1];

endmodule

// File: rtl/mul_wave_array_chk.sv
module mul_wave_array_chk
   import mul_wave_pkg::*;
#(
   parameter int unsigned W   = 8,
   parameter int unsigned SEG = 2
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic out_valid
);

   localparam int unsigned LAT = pipe_latency(W, SEG);
   localparam int unsigned CW  = $clog2(LAT + 1) + 1;

   logic [CW-1:0] idle_run;
   logic [CW-1:0] in_flight;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_run  <= CW'(LAT);
         in_flight <= '0;
      end else begin
         if (in_valid)                 idle_run <= '0;
         else if (idle_run < CW'(LAT)) idle_run <= idle_run + 1'b1;
         in_flight <= in_flight + CW'(in_valid) - CW'(out_valid);
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

   AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_run == CW'(LAT)) |-> !out_valid); // R5

   AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (in_flight != '0)); // R3

   AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight <= CW'(LAT)); // R4

endmodule

bind mul_wave_array mul_wave_array_chk #(.W(W), .SEG(SEG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid)
);

// File: tb/mul_wave_array_tb.sv
`timescale 1ns/1ps
module mul_wave_array_tb;

   localparam int L8 = 8 + 16 / 2;  // R3: W + 2W/SEG for W=8, SEG=2
   localparam int L4 = 4 + 8 / 1;   // R3: W + 2W/SEG for W=4, SEG=1

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vin = 1'b0;
   logic [7:0]  xin = '0;
   logic [7:0]  yin = '0;
   logic        ov8, ov4;
   logic [15:0] op8;
   logic [7:0]  op4;

   int tests = 0;
   int fails = 0;
   int in_cnt = 0;
   int out_cnt = 0;
   bit done = 1'b0;

   logic        pv8 [L8];
   logic [7:0]  px8 [L8];
   logic [7:0]  py8 [L8];
   logic        pv4 [L4];
   logic [3:0]  px4 [L4];
   logic [3:0]  py4 [L4];

   always #2.5 clk = ~clk;

   mul_wave_array #(.W(8), .SEG(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_x(xin), .in_y(yin),
      .out_valid(ov8), .out_prod(op8)
   );

   mul_wave_array #(.W(4), .SEG(1)) u_dut_n4 (
      .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_x(xin[3:0]), .in_y(yin[3:0]),
      .out_valid(ov4), .out_prod(op4)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: model the sample at the rising edge, check at the falling edge
   task automatic step();
      @(posedge clk);
      for (int j = L8 - 1; j > 0; j--) begin
         pv8[j] = pv8[j-1]; px8[j] = px8[j-1]; py8[j] = py8[j-1];
      end
      for (int j = L4 - 1; j > 0; j--) begin
         pv4[j] = pv4[j-1]; px4[j] = px4[j-1]; py4[j] = py4[j-1];
      end
      pv8[0] = vin & rst_n; px8[0] = xin;      py8[0] = yin;
      pv4[0] = vin & rst_n; px4[0] = xin[3:0]; py4[0] = yin[3:0];
      if (vin && rst_n) in_cnt++;
      @(negedge clk);
      if (!rst_n) begin
         chk("R1 out_valid in reset (n=8)", {15'd0, ov8}, 16'd0);
         chk("R1 out_valid in reset (n=4)", {15'd0, ov4}, 16'd0);
      end else begin
         if (ov8 === 1'b1) out_cnt++;
         chk(pv8[L8-1] ? "R3 valid latency (n=8)" : "R5 bubble gives no result (n=8)",
             {15'd0, ov8}, {15'd0, pv8[L8-1]});
         chk(pv4[L4-1] ? "R3 valid latency (n=4)" : "R5 bubble gives no result (n=4)",
             {15'd0, ov4}, {15'd0, pv4[L4-1]});
         if (pv8[L8-1]) begin
            if (px8[L8-1] == 8'd0 || py8[L8-1] == 8'd0 ||
                (px8[L8-1] == 8'hFF && py8[L8-1] == 8'hFF))
               chk("R7 corner product", op8, 16'(px8[L8-1]) * 16'(py8[L8-1]));
            else
               chk("R2 product n=8", op8, 16'(px8[L8-1]) * 16'(py8[L8-1]));
         end
         if (pv4[L4-1])
            chk("R6 product n=4", {8'd0, op4}, 16'(px4[L4-1]) * 16'(py4[L4-1]));
      end
   endtask

   initial begin
      for (int j = 0; j < L8; j++) begin pv8[j] = 1'b0; px8[j] = '0; py8[j] = '0; end
      for (int j = 0; j < L4; j++) begin pv4[j] = 1'b0; px4[j] = '0; py4[j] = '0; end
      // reset phase, with operands offered that must be ignored
      vin = 1'b1; xin = 8'hA5; yin = 8'h3C;
      for (int c = 0; c < 4; c++) step();
      @(negedge clk);
      rst_n = 1'b1; vin = 1'b0;
      for (int c = 0; c < 3; c++) step();
      // full sweep of 8x8 operand pairs, back to back, with periodic bubbles
      for (int i = 0; i < 65536; i++) begin
         xin = i[7:0];
         yin = i[15:8];
         vin = ((i % 13) != 5);
         // R7: force the all-ones pair onto a valid cycle explicitly
         if (i == 65535) vin = 1'b1;
         step();
      end
      // drain
      vin = 1'b0; xin = 8'hFF; yin = 8'hFF;
      for (int c = 0; c < L8 + 4; c++) step();
      chk("R4 results delivered equal pairs accepted", 16'(out_cnt), 16'(in_cnt));
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule